// File: doc/BRIEF.md
# ADC Input Channel Sequencer

This block chooses which analog multiplexer input the next conversion of an eight-input converter samples. It keeps an active configuration that holds an input-referencing code, a last-channel number and a scanning mode. Each end-of-conversion strobe moves it to the next slot. Its outputs drive the front end: a positive input number, a partner input number, a code for the negative-side reference, and a temperature-sensor select.

A scan always starts at input 0 and stops at the programmed last channel. When the referencing code calls for input pairs, the scan steps two inputs at a time. The even input is the positive side and the odd input is the negative side. One mode adds a temperature-sensor slot after the final channel. A separate "keep" mode changes the other fields without touching the scan mode. Such a rewrite restarts the scan only when it changes the pairing or the last channel. When scanning is off, every conversion uses the channel number held in the last-channel field.

Top module: `adc_chan_sequencer`

## Requirements
- R1: After reset the outputs are pos_ch=0, neg_ch=0, neg_sel=0 (ground) and temp_sel=0. The active configuration is code 111, last channel 0 and mode 00.
- R2: The configuration word is {code[7:5], last[4:2], mode[1:0]}. Codes 000 and 001 (bipolar pairs) and codes 100 and 101 (unipolar pairs) give neg_sel=2 and neg_ch=pos_ch^1. Codes 010 and 110 give neg_sel=1 (COM). Code 111 gives neg_sel=0 (ground). Code 011 gives temp_sel=1 with pos_ch=0, neg_ch=0 and neg_sel=0. Any temperature slot drives these same values.
- R3: In mode 00, pos_ch equals the last-channel field, and end-of-conversion strobes change nothing.
- R4: In mode 11 with unpaired inputs, the slots go 0, 1, … last. After the last slot the next strobe returns to 0.
- R5: Mode 10 inserts one temperature slot (temp_sel=1) after the last channel. The following strobe returns to input 0.
- R6: With a paired code the slot steps by 2, pos_ch is always even, and the scan ends at the pair that contains the last channel. The last channel's low bit is ignored.
- R7: Writing mode 00, 10 or 11 sets the active mode and puts the slot at input 0, visible on the cycle after the write.
- R8: A mode-01 write that changes the pairing (code bit 6) or the last channel restarts at input 0. Any other mode-01 write keeps the current slot and applies the new code at once.
- R9: A mode-01 write never changes the active mode. This includes the case where scanning is off.
- R10: If a write and a strobe arrive in the same cycle, a restarting write wins. A non-restarting write lets the strobe advance the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | 8 | New configuration word {code, last, mode} |
| eoc | input | 1 | End-of-conversion strobe; advances the slot |
| pos_ch | output | 3 | Positive-side input number |
| neg_ch | output | 3 | Negative-side partner input when paired, else 0 |
| neg_sel | output | 2 | Negative reference: 0 ground, 1 COM, 2 partner input |
| temp_sel | output | 1 | Temperature sensor selected |

## Verification
The hardest condition to reach is a keep-mode rewrite that arrives partway through a scan and changes only the code. It must leave the slot in place, and it can also coincide with a strobe. Directed steps first move a scan to its middle. They then issue keep-mode writes with the same last channel, once alone and once together with a strobe, and then writes that change the pairing or the last channel. A seeded random phase mixes writes of all four modes with strobes, so that restarts land on temperature slots and on the final slots of scans.

// File: rtl/chseq_pkg.sv
package chseq_pkg;

   typedef enum logic [1:0] {
      NEG_GND  = 2'd0,
      NEG_COM  = 2'd1,
      NEG_PAIR = 2'd2
   } neg_sel_e;

   typedef enum logic [1:0] {
      MODE_OFF    = 2'd0,
      MODE_KEEP   = 2'd1,
      MODE_SCAN_T = 2'd2,
      MODE_SCAN   = 2'd3
   } seq_mode_e;

   localparam logic [2:0] CODE_TEMP  = 3'b011;
   localparam logic [2:0] CODE_RESET = 3'b111;

   // middle code bit low selects paired inputs
   function automatic logic code_paired(input logic [2:0] code);
      return ~code[1];
   endfunction

   function automatic neg_sel_e code_ref(input logic [2:0] code);
      neg_sel_e r;
      if (code[1] == 1'b0)        r = NEG_PAIR;
      else if (code[0] == 1'b0)   r = NEG_COM;
      else                        r = NEG_GND;
      return r;
   endfunction

   function automatic logic mode_scans(input seq_mode_e m);
      return (m == MODE_SCAN) || (m == MODE_SCAN_T);
   endfunction

endpackage

// File: rtl/chseq_cfg.sv
module chseq_cfg
   import chseq_pkg::*;
#(
   parameter int CH_W  = 3,
   localparam int CFG_W = CH_W + 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_word,
   output logic [2:0]       code,
   output logic [CH_W-1:0]  last_ch,
   output seq_mode_e        mode,
   output logic             restart
);

   logic [2:0]      new_code;
   logic [CH_W-1:0] new_last;
   seq_mode_e       new_mode;
   logic            layout_change;

   assign new_code = cfg_word[CFG_W-1 -: 3];
   assign new_last = cfg_word[CH_W+1:2];
   assign new_mode = seq_mode_e'(cfg_word[1:0]);

   assign layout_change = (code_paired(new_code) != code_paired(code)) ||
                          (new_last != last_ch);

   assign restart = cfg_we && ((new_mode != MODE_KEEP) || layout_change);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code    <= CODE_RESET;
         last_ch <= '0;
         mode    <= MODE_OFF;
      end else if (cfg_we) begin
         code    <= new_code;
         last_ch <= new_last;
         if (new_mode != MODE_KEEP) mode <= new_mode;
      end
   end

endmodule

// File: rtl/chseq_slot.sv
module chseq_slot
   import chseq_pkg::*;
#(
   parameter int CH_W     = 3,
   parameter bit HAS_TEMP = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart,
   input  logic            eoc,
   input  seq_mode_e       mode,
   input  logic            paired,
   input  logic [CH_W-1:0] last_ch,
   output logic [CH_W-1:0] idx,
   output logic            tmp_slot
);

   logic [CH_W-1:0] final_idx;
   logic [CH_W-1:0] step;
   logic            temp_ok;
   logic            scanning;

   assign final_idx = paired ? (last_ch & ~CH_W'(1)) : last_ch;
   assign step      = paired ? CH_W'(2) : CH_W'(1);
   assign scanning  = mode_scans(mode);

   generate
      if (HAS_TEMP) begin : g_temp
         assign temp_ok = (mode == MODE_SCAN_T);
      end else begin : g_no_temp
         assign temp_ok = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx      <= '0;
         tmp_slot <= 1'b0;
      end else if (restart) begin
         idx      <= '0;
         tmp_slot <= 1'b0;
      end else if (eoc && scanning) begin
         if (tmp_slot) begin
            idx      <= '0;
            tmp_slot <= 1'b0;
         end else if (idx == final_idx) begin
            if (temp_ok) tmp_slot <= 1'b1;
            else         idx      <= '0;
         end else begin
            idx <= idx + step;
         end
      end
   end

endmodule

// File: rtl/chseq_map.sv
module chseq_map
   import chseq_pkg::*;
#(
   parameter int CH_W = 3
) (
   input  logic [2:0]      code,
   input  logic [CH_W-1:0] last_ch,
   input  seq_mode_e       mode,
   input  logic [CH_W-1:0] idx,
   input  logic            tmp_slot,
   output logic [CH_W-1:0] pos_ch,
   output logic [CH_W-1:0] neg_ch,
   output neg_sel_e        neg_sel,
   output logic            temp_sel
);

   logic [CH_W-1:0] chan;

   assign chan = (mode == MODE_OFF) ? last_ch : idx;

   always_comb begin
      temp_sel = tmp_slot || (code == CODE_TEMP);
      pos_ch   = '0;
      neg_ch   = '0;
      neg_sel  = NEG_GND;
      if (!temp_sel) begin
         pos_ch  = chan;
         neg_sel = code_ref(code);
         if (neg_sel == NEG_PAIR) neg_ch = chan ^ CH_W'(1);
      end
   end

endmodule

// File: rtl/adc_chan_sequencer.sv
module adc_chan_sequencer
   import chseq_pkg::*;
#(
   parameter int NUM_INPUTS = 8,
   parameter bit HAS_TEMP   = 1'b1,
   localparam int CH_W  = $clog2(NUM_INPUTS),
   localparam int CFG_W = CH_W + 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic             eoc,
   output logic [CH_W-1:0]  pos_ch,
   output logic [CH_W-1:0]  neg_ch,
   output logic [1:0]       neg_sel,
   output logic             temp_sel
);

   generate
      if (NUM_INPUTS < 2 || (NUM_INPUTS & (NUM_INPUTS - 1)) != 0) begin : g_bad_inputs
         $error("NUM_INPUTS must be a power of two of at least 2");
      end
   endgenerate

   logic [2:0]      code;
   logic [CH_W-1:0] last_ch;
   seq_mode_e       mode;
   logic            restart;
   logic [CH_W-1:0] slot_idx;
   logic            slot_tmp;
   neg_sel_e        neg_sel_w;

   chseq_cfg #(.CH_W(CH_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_word (cfg_word),
      .code     (code),
      .last_ch  (last_ch),
      .mode     (mode),
      .restart  (restart)
   );

   chseq_slot #(.CH_W(CH_W), .HAS_TEMP(HAS_TEMP)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .eoc      (eoc),
      .mode     (mode),
      .paired   (code_paired(code)),
      .last_ch  (last_ch),
      .idx      (slot_idx),
      .tmp_slot (slot_tmp)
   );

   chseq_map #(.CH_W(CH_W)) u_map (
      .code     (code),
      .last_ch  (last_ch),
      .mode     (mode),
      .idx      (slot_idx),
      .tmp_slot (slot_tmp),
      .pos_ch   (pos_ch),
      .neg_ch   (neg_ch),
      .neg_sel  (neg_sel_w),
      .temp_sel (temp_sel)
   );

   assign neg_sel = neg_sel_w;

endmodule

// File: rtl/adc_chan_sequencer_chk.sv
module adc_chan_sequencer_chk
   import chseq_pkg::*;
#(
   parameter int CH_W     = 3,
   parameter bit HAS_TEMP = 1'b1,
   localparam int CFG_W = CH_W + 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [CFG_W-1:0] cfg_word,
   input logic             eoc,
   input logic [CH_W-1:0]  pos_ch,
   input logic [1:0]       neg_sel,
   input logic             temp_sel,
   input logic [2:0]       code,
   input logic [CH_W-1:0]  last_ch,
   input seq_mode_e        mode,
   input logic             restart,
   input logic [CH_W-1:0]  slot_idx,
   input logic             slot_tmp
);

   logic            pairs;
   logic [CH_W-1:0] end_idx;
   logic [CH_W-1:0] inc;
   logic            moving;

   assign pairs   = (code[1] == 1'b0);
   assign end_idx = pairs ? {last_ch[CH_W-1:1], 1'b0} : last_ch;
   assign inc     = pairs ? CH_W'(2) : CH_W'(1);
   assign moving  = eoc && !restart && mode_scans(mode);

   assert_off_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_OFF && !cfg_we) |=> ($stable(pos_ch) && $stable(neg_sel) && $stable(temp_sel)));

   assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (slot_idx == '0 && !slot_tmp));

   assert_pair_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_scans(mode) && pairs && !temp_sel) |-> (pos_ch[0] == 1'b0));

   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (moving && !slot_tmp && slot_idx != end_idx) |=> (slot_idx == $past(slot_idx) + $past(inc)));

   assert_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (moving && mode == MODE_SCAN && slot_idx == end_idx) |=> (slot_idx == '0 && !slot_tmp));

   assert_temp_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_TEMP && moving && mode == MODE_SCAN_T && !slot_tmp && slot_idx == end_idx) |=> slot_tmp);

   assert_temp_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (moving && slot_tmp) |=> (slot_idx == '0 && !slot_tmp));

   assert_keep_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_word[1:0] == 2'b01) |=> $stable(mode));

   assert_temp_ground_R2: assert property (@(posedge clk) disable iff (!rst_n)
      temp_sel |-> (neg_sel == 2'd0 && pos_ch == '0));

endmodule

bind adc_chan_sequencer adc_chan_sequencer_chk #(.CH_W(CH_W), .HAS_TEMP(HAS_TEMP)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_word (cfg_word),
   .eoc      (eoc),
   .pos_ch   (pos_ch),
   .neg_sel  (neg_sel),
   .temp_sel (temp_sel),
   .code     (code),
   .last_ch  (last_ch),
   .mode     (mode),
   .restart  (restart),
   .slot_idx (slot_idx),
   .slot_tmp (slot_tmp)
);

// File: tb/adc_chan_sequencer_test.sv
`timescale 1ns/1ps
module adc_chan_sequencer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_word = '0;
   logic       eoc = 1'b0;
   logic [2:0] pos_ch;
   logic [2:0] neg_ch;
   logic [1:0] neg_sel;
   logic       temp_sel;

   int n_checks = 0;
   int n_fails  = 0;

   // reference model state
   logic [2:0] m_code = 3'b111;
   logic [2:0] m_last = 3'd0;
   logic [1:0] m_mode = 2'd0;
   logic [2:0] m_idx  = 3'd0;
   logic       m_tmp  = 1'b0;

   always #2 clk = ~clk;

   adc_chan_sequencer uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_word (cfg_word),
      .eoc      (eoc),
      .pos_ch   (pos_ch),
      .neg_ch   (neg_ch),
      .neg_sel  (neg_sel),
      .temp_sel (temp_sel)
   );

   function automatic logic [7:0] mk(input logic [2:0] c, input logic [2:0] l, input logic [1:0] m);
      return {c, l, m};
   endfunction

   function automatic logic is_pair(input logic [2:0] c);
      return (c[1] == 1'b0);
   endfunction

   function automatic string auto_tag();
      if (m_tmp)             return "R5";
      if (m_mode == 2'd0)    return "R3";
      if (is_pair(m_code))   return "R6";
      return "R4";
   endfunction

   task automatic model_step(input bit we, input logic [7:0] w, input bit e);
      bit rs;
      logic [2:0] fin;
      rs = 1'b0;
      if (we) begin
         if (w[1:0] == 2'd1)
            rs = (is_pair(w[7:5]) != is_pair(m_code)) || (w[4:2] != m_last);
         else begin
            m_mode = w[1:0];
            rs = 1'b1;
         end
         m_code = w[7:5];
         m_last = w[4:2];
      end
      if (rs) begin
         m_idx = 3'd0;
         m_tmp = 1'b0;
      end else if (e && m_mode[1]) begin
         fin = is_pair(m_code) ? {m_last[2:1], 1'b0} : m_last;
         if (m_tmp) begin
            m_idx = 3'd0;
            m_tmp = 1'b0;
         end else if (m_idx == fin) begin
            if (m_mode == 2'd2) m_tmp = 1'b1;
            else                m_idx = 3'd0;
         end else begin
            m_idx = m_idx + (is_pair(m_code) ? 3'd2 : 3'd1);
         end
      end
   endtask

   task automatic check_out(input string tag);
      logic [2:0] e_pos, e_neg;
      logic [1:0] e_sel;
      logic       e_tmp;
      e_tmp = m_tmp || (m_code == 3'b011);
      e_pos = 3'd0;
      e_neg = 3'd0;
      e_sel = 2'd0;
      if (!e_tmp) begin
         e_pos = (m_mode == 2'd0) ? m_last : m_idx;
         if (is_pair(m_code))      e_sel = 2'd2;
         else if (!m_code[0])      e_sel = 2'd1;
         else                      e_sel = 2'd0;
         if (e_sel == 2'd2) e_neg = e_pos ^ 3'd1;
      end
      n_checks++;
      if (pos_ch !== e_pos || neg_ch !== e_neg || neg_sel !== e_sel || temp_sel !== e_tmp) begin
         n_fails++;
         $display("FAIL %s: got pos=%0d neg=%0d sel=%0d temp=%0d expected pos=%0d neg=%0d sel=%0d temp=%0d",
                  tag, pos_ch, neg_ch, neg_sel, temp_sel, e_pos, e_neg, e_sel, e_tmp);
      end
   endtask

   task automatic step(input bit we, input logic [7:0] w, input bit e, input string tag);
      cfg_we   = we;
      cfg_word = w;
      eoc      = e;
      model_step(we, w, e);
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      eoc    = 1'b0;
      check_out((tag == "") ? auto_tag() : tag);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20250611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R1");

      // disabled: channel field selects, strobes ignored
      step(1'b1, mk(3'b111, 3'd5, 2'd0), 1'b0, "R3");
      step(1'b0, 8'h00, 1'b1, "R3");
      step(1'b0, 8'h00, 1'b1, "R3");
      // referencing codes
      step(1'b1, mk(3'b010, 3'd3, 2'd0), 1'b0, "R2");
      step(1'b1, mk(3'b000, 3'd3, 2'd0), 1'b0, "R2");
      step(1'b1, mk(3'b101, 3'd6, 2'd0), 1'b0, "R2");
      step(1'b1, mk(3'b011, 3'd6, 2'd0), 1'b0, "R2");
      // single scan 0..2
      step(1'b1, mk(3'b111, 3'd2, 2'd3), 1'b0, "R7");
      for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1, "R4");
      // scan with temperature slot
      step(1'b1, mk(3'b110, 3'd1, 2'd2), 1'b0, "R7");
      for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1, "R5");
      // paired scans; low bit of last ignored
      step(1'b1, mk(3'b100, 3'd4, 2'd3), 1'b0, "R7");
      for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 1'b1, "R6");
      step(1'b1, mk(3'b001, 3'd5, 2'd2), 1'b0, "R7");
      for (int i = 0; i < 5; i++) step(1'b0, 8'h00, 1'b1, "R6");
      // keep-mode rewrites mid scan
      step(1'b1, mk(3'b111, 3'd3, 2'd3), 1'b0, "R7");
      step(1'b0, 8'h00, 1'b1, "R4");
      step(1'b0, 8'h00, 1'b1, "R4");
      step(1'b1, mk(3'b110, 3'd3, 2'd1), 1'b0, "R8");
      step(1'b1, mk(3'b110, 3'd2, 2'd1), 1'b0, "R8");
      step(1'b0, 8'h00, 1'b1, "R4");
      step(1'b1, mk(3'b100, 3'd2, 2'd1), 1'b0, "R8");
      // simultaneous write and strobe
      step(1'b1, mk(3'b111, 3'd4, 2'd3), 1'b0, "R7");
      step(1'b0, 8'h00, 1'b1, "R4");
      step(1'b1, mk(3'b010, 3'd4, 2'd1), 1'b1, "R10");
      step(1'b1, mk(3'b010, 3'd4, 2'd3), 1'b1, "R10");
      step(1'b1, mk(3'b010, 3'd6, 2'd1), 1'b1, "R10");
      // keep mode while disabled stays disabled
      step(1'b1, mk(3'b111, 3'd1, 2'd0), 1'b0, "R3");
      step(1'b1, mk(3'b111, 3'd6, 2'd1), 1'b0, "R9");
      step(1'b0, 8'h00, 1'b1, "R9");
      step(1'b1, mk(3'b100, 3'd7, 2'd1), 1'b1, "R9");

      // seeded random mix
      for (int i = 0; i < 4000; i++) begin
         bit we, e;
         logic [7:0] w;
         we = ($urandom % 8) == 0;
         e  = ($urandom % 2) == 0;
         w  = 8'($urandom);
         step(we, w, e, "");
      end

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
      $finish;
   end

endmodule